// File: doc/BRIEF.md
# MSI and Legacy Interrupt Aggregator

This block gathers interrupts for a bus host controller. Inbound message writes arrive as a strobe with a vector number. Each one sets a pending bit. The pending bits are spread over a set of status groups. Each group has its own write-one-to-set and write-one-to-clear enable registers, and drives one interrupt line. Four level-sensitive legacy interrupt inputs are synchronised, latched and masked in the same way, with one output line per input.

Each output line is gated by an arm/serve state. When software services a line, it clears the pending bits or masks them, and the line drops. From then on the line stays quiet, even if new pending bits arrive, until software writes that line's code to the shared end-of-interrupt register. At that point the line asserts again at once if any enabled bit is still pending. The vectors are interleaved: vector v goes to group v mod NUM_GRP, at bit v div NUM_GRP.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all status and enable bits are zero and every output line is low.
- R2: A message strobe with vector v sets bit v/8 of MSI group v%8. The status of group g reads at byte address 0x100+0x10*g, in bits [3:0].
- R3: Writing a one to a status bit clears it, and zero bits leave it unchanged. When a message strobe and a clear hit the same bit in the same cycle, the bit stays set.
- R4: Writing ones at status address +0x4 sets enable bits, and writing ones at +0x8 clears them. A read of either address returns the current enable mask.
- R5: An MSI output is high while its group is armed and (status AND enable) is nonzero. Pending bits that are not enabled never raise it.
- R6: Once a line has been high and its enabled pending bits go to zero, the line stays low, even for new pending bits, until its end-of-interrupt code is written.
- R7: A write of value c to the end-of-interrupt register at 0x040 re-arms MSI group c-4 (for c from 4 to 11) or legacy line c (for c from 0 to 3). Other lines are not affected. A re-armed line asserts at once if enabled bits are pending.
- R8: Legacy line n has its status at 0x180+0x10*n, enable-set at +0x4 and enable-clear at +0x8, all in bit 0. The status bit is set while the input is high, two clock cycles after synchronisation. It is cleared by writing one, and the line follows the R5 and R6 gating.
- R9: A read of any address outside the mapped registers, including the end-of-interrupt register, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid in the same cycle as the request |
| msg_valid_i | input | 1 | Inbound message write strobe |
| msg_vec_i | input | log2(NUM_VEC) | Vector carried by the message |
| legacy_i | input | NUM_LEG | Asynchronous level interrupt inputs |
| msi_irq_o | output | NUM_GRP | One interrupt line per MSI group |
| leg_irq_o | output | NUM_LEG | One interrupt line per legacy input |

## Verification
The bench builds the block with its default parameters: 32 vectors in 8 groups of 4 bits, 4 legacy lines and a two-stage synchroniser. With these values, every end-of-interrupt code from 0 to 11 and every vector-to-group interleave falls within the random stimulus. That stimulus also produces same-cycle collisions between a message strobe and a status clear, and end-of-interrupt writes that arrive while enabled bits are still pending. Directed sequences cover the serve-then-quiet window, EOI codes written to the wrong line, and the latency of the legacy synchroniser.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned MSI_BASE  = 'h100;
  localparam int unsigned LEG_BASE  = 'h180;
  localparam int unsigned EOI_ADDR  = 'h040;
  localparam int unsigned STRIDE    = 'h10;
  localparam logic [3:0]  OFS_STAT  = 4'h0;
  localparam logic [3:0]  OFS_ENSET = 4'h4;
  localparam logic [3:0]  OFS_ENCLR = 4'h8;
  localparam int unsigned EOI_W     = 8;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_STAT,
    ACC_ENSET,
    ACC_ENCLR
  } acc_kind_e;

  function automatic acc_kind_e decode_ofs(input logic [3:0] ofs);
    case (ofs)
      OFS_STAT:  return ACC_STAT;
      OFS_ENSET: return ACC_ENSET;
      OFS_ENCLR: return ACC_ENCLR;
      default:   return ACC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic eoi_i,
  output logic irq_o
);
  logic armed_q, fired_q;

  assign irq_o = armed_q & active_i;

  // fired_q: line has been high since last EOI; drop of active then disarms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      fired_q <= 1'b0;
    end else if (eoi_i) begin
      armed_q <= 1'b1;
      fired_q <= 1'b0;
    end else if (fired_q && !active_i) begin
      armed_q <= 1'b0;
      fired_q <= 1'b0;
    end else if (irq_o) begin
      fired_q <= 1'b1;
    end
  end

  a_r6_quiet_after_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired_q && !active_i && !eoi_i) |=> !irq_o);

  a_r7_eoi_rearms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_i |=> (irq_o == active_i));
endmodule

// File: rtl/irq_group.sv
module irq_group #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] stat_clr_i,
  input  logic [W-1:0] en_set_i,
  input  logic [W-1:0] en_clr_i,
  input  logic         eoi_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  logic [W-1:0] stat_q, en_q;
  logic         active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~stat_clr_i) | set_i;  // set wins
      en_q   <= (en_q | en_set_i) & ~en_clr_i;
    end
  end

  assign active = |(stat_q & en_q);
  assign stat_o = stat_q;
  assign en_o   = en_q;

  irq_gate u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .eoi_i   (eoi_i),
    .irq_o   (irq_o)
  );

  a_r3_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)));

  a_r3_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr_i != '0 && set_i == '0) |=> ((stat_q & $past(stat_clr_i)) == '0));

  a_r4_en_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_clr_i != '0) |=> ((en_q & $past(en_clr_i)) == '0));

  a_r4_en_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_set_i != '0 && en_clr_i == '0) |=> ((en_q & $past(en_set_i)) == $past(en_set_i)));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_VEC     = 32,
  parameter int unsigned NUM_GRP     = 8,
  parameter int unsigned NUM_LEG     = 4,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned VEC_W      = $clog2(NUM_VEC),
  localparam int unsigned GRP_W      = $clog2(NUM_GRP),
  localparam int unsigned BPG        = NUM_VEC / NUM_GRP
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic                msg_valid_i,
  input  logic [VEC_W-1:0]    msg_vec_i,
  input  logic [NUM_LEG-1:0]  legacy_i,
  output logic [NUM_GRP-1:0]  msi_irq_o,
  output logic [NUM_LEG-1:0]  leg_irq_o
);
  localparam int unsigned BLK_W = ADDR_W - 4;

  logic             wr, rd;
  logic [BLK_W-1:0] blk;
  acc_kind_e        kind;
  logic             eoi_wr;
  logic [EOI_W-1:0] eoi_code;

  assign wr       = req_i & we_i;
  assign rd       = req_i & ~we_i;
  assign blk      = addr_i[ADDR_W-1:4];
  assign kind     = decode_ofs(addr_i[3:0]);
  assign eoi_wr   = wr && (addr_i == ADDR_W'(EOI_ADDR));
  assign eoi_code = wdata_i[EOI_W-1:0];

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:EOI_W];

  // MSI groups
  logic [BPG-1:0] msi_stat [NUM_GRP];
  logic [BPG-1:0] msi_en   [NUM_GRP];
  logic [NUM_GRP-1:0] msi_hit;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_msi
    logic [BPG-1:0] set, sclr, eset, eclr;
    logic           eoi;

    assign msi_hit[g] = (blk == BLK_W'(MSI_BASE / STRIDE + g));
    assign set  = (msg_valid_i && msg_vec_i[GRP_W-1:0] == GRP_W'(g))
                  ? (BPG'(1) << msg_vec_i[VEC_W-1:GRP_W]) : '0;
    assign sclr = (wr && msi_hit[g] && kind == ACC_STAT)  ? wdata_i[BPG-1:0] : '0;
    assign eset = (wr && msi_hit[g] && kind == ACC_ENSET) ? wdata_i[BPG-1:0] : '0;
    assign eclr = (wr && msi_hit[g] && kind == ACC_ENCLR) ? wdata_i[BPG-1:0] : '0;
    assign eoi  = eoi_wr && (eoi_code == EOI_W'(g + NUM_LEG));

    irq_group #(.W(BPG)) u_grp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (set),
      .stat_clr_i(sclr),
      .en_set_i  (eset),
      .en_clr_i  (eclr),
      .eoi_i     (eoi),
      .stat_o    (msi_stat[g]),
      .en_o      (msi_en[g]),
      .irq_o     (msi_irq_o[g])
    );

    a_r5_msi_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      msi_irq_o[g] |-> ((msi_stat[g] & msi_en[g]) != '0));
  end

  // Legacy lines
  logic [NUM_LEG-1:0] leg_sync;
  logic [NUM_LEG-1:0] leg_stat, leg_en;
  logic [NUM_LEG-1:0] leg_hit;

  irq_sync #(.W(NUM_LEG), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (legacy_i),
    .q_o   (leg_sync)
  );

  for (genvar n = 0; n < NUM_LEG; n++) begin : g_leg
    logic sclr, eset, eclr, eoi;

    assign leg_hit[n] = (blk == BLK_W'(LEG_BASE / STRIDE + n));
    assign sclr = wr && leg_hit[n] && kind == ACC_STAT  && wdata_i[0];
    assign eset = wr && leg_hit[n] && kind == ACC_ENSET && wdata_i[0];
    assign eclr = wr && leg_hit[n] && kind == ACC_ENCLR && wdata_i[0];
    assign eoi  = eoi_wr && (eoi_code == EOI_W'(n));

    irq_group #(.W(1)) u_grp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (leg_sync[n]),
      .stat_clr_i(sclr),
      .en_set_i  (eset),
      .en_clr_i  (eclr),
      .eoi_i     (eoi),
      .stat_o    (leg_stat[n]),
      .en_o      (leg_en[n]),
      .irq_o     (leg_irq_o[n])
    );

    a_r8_leg_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      leg_irq_o[n] |-> (leg_stat[n] && leg_en[n]));
  end

  // Read mux
  always_comb begin
    rdata_o = '0;
    if (rd) begin
      for (int g = 0; g < NUM_GRP; g++) begin
        if (msi_hit[g]) begin
          case (kind)
            ACC_STAT:             rdata_o = DATA_W'(msi_stat[g]);
            ACC_ENSET, ACC_ENCLR: rdata_o = DATA_W'(msi_en[g]);
            default:              rdata_o = '0;
          endcase
        end
      end
      for (int n = 0; n < NUM_LEG; n++) begin
        if (leg_hit[n]) begin
          case (kind)
            ACC_STAT:             rdata_o = DATA_W'(leg_stat[n]);
            ACC_ENSET, ACC_ENCLR: rdata_o = DATA_W'(leg_en[n]);
            default:              rdata_o = '0;
          endcase
        end
      end
    end
  end

  // Vector-ordered view of pending bits for the routing check
  logic [NUM_VEC-1:0] vec_pend;
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign vec_pend[v] = msi_stat[v % NUM_GRP][v / NUM_GRP];
  end

  a_r2_vec_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i |=> vec_pend[$past(msg_vec_i)]);

  a_r9_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (rdata_o == '0));
endmodule

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb_top;
  localparam int NG = 8, NL = 4, BPG = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        msg_valid = 0;
  logic [4:0]  msg_vec = '0;
  logic [3:0]  legacy = '0;
  logic [7:0]  msi_irq;
  logic [3:0]  leg_irq;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  irq_aggregator dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .msg_valid_i(msg_valid), .msg_vec_i(msg_vec),
    .legacy_i(legacy), .msi_irq_o(msi_irq), .leg_irq_o(leg_irq)
  );

  // Reference model built from the requirements
  logic [BPG-1:0] m_st [NG];
  logic [BPG-1:0] m_en [NG];
  logic [NG-1:0]  m_arm, m_fir;
  logic [NL-1:0]  l_st, l_en, l_arm, l_fir, l_s0, l_s1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin m_st[g] <= '0; m_en[g] <= '0; end
      m_arm <= '1; m_fir <= '0;
      l_st <= '0; l_en <= '0; l_arm <= '1; l_fir <= '0; l_s0 <= '0; l_s1 <= '0;
    end else begin
      for (int g = 0; g < NG; g++) begin
        logic [BPG-1:0] set, clr, es, ec;
        logic act, eoi;
        int base;
        base = 'h100 + 16 * g;
        act = |(m_st[g] & m_en[g]);
        set = (msg_valid && (msg_vec % NG) == g) ? (BPG'(1) << (msg_vec / NG)) : '0;
        clr = (req && we && addr == 12'(base))     ? wdata[BPG-1:0] : '0;
        es  = (req && we && addr == 12'(base + 4)) ? wdata[BPG-1:0] : '0;
        ec  = (req && we && addr == 12'(base + 8)) ? wdata[BPG-1:0] : '0;
        eoi = req && we && addr == 12'h040 && wdata[7:0] == 8'(g + NL);
        m_st[g] <= (m_st[g] & ~clr) | set;
        m_en[g] <= (m_en[g] | es) & ~ec;
        if (eoi) begin m_arm[g] <= 1; m_fir[g] <= 0; end
        else if (m_fir[g] && !act) begin m_arm[g] <= 0; m_fir[g] <= 0; end
        else if (m_arm[g] && act) m_fir[g] <= 1;
      end
      for (int n = 0; n < NL; n++) begin
        logic clr, es, ec, act, eoi;
        int base;
        base = 'h180 + 16 * n;
        act = l_st[n] & l_en[n];
        clr = req && we && addr == 12'(base)     && wdata[0];
        es  = req && we && addr == 12'(base + 4) && wdata[0];
        ec  = req && we && addr == 12'(base + 8) && wdata[0];
        eoi = req && we && addr == 12'h040 && wdata[7:0] == 8'(n);
        l_st[n] <= (l_st[n] & ~clr) | l_s1[n];
        l_en[n] <= (l_en[n] | es) & ~ec;
        if (eoi) begin l_arm[n] <= 1; l_fir[n] <= 0; end
        else if (l_fir[n] && !act) begin l_arm[n] <= 0; l_fir[n] <= 0; end
        else if (l_arm[n] && act) l_fir[n] <= 1;
      end
      l_s0 <= legacy;
      l_s1 <= l_s0;
    end
  end

  function automatic logic [7:0] exp_msi();
    logic [7:0] r;
    for (int g = 0; g < NG; g++) r[g] = m_arm[g] & (|(m_st[g] & m_en[g]));
    return r;
  endfunction

  function automatic logic [3:0] exp_leg();
    return l_arm & l_st & l_en;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    for (int g = 0; g < NG; g++) begin
      if (a == 12'('h100 + 16*g)) return 32'(m_st[g]);
      if (a == 12'('h104 + 16*g) || a == 12'('h108 + 16*g)) return 32'(m_en[g]);
    end
    for (int n = 0; n < NL; n++) begin
      if (a == 12'('h180 + 16*n)) return 32'(l_st[n]);
      if (a == 12'('h184 + 16*n) || a == 12'('h188 + 16*n)) return 32'(l_en[n]);
    end
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag);
    chk({tag, " msi lines"}, 32'(msi_irq), 32'(exp_msi()));
    chk({tag, " legacy lines"}, 32'(leg_irq), 32'(exp_leg()));
  endtask

  // Called at a negedge; returns at the next negedge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    req = 1; we = 0; addr = a;
    #0.5;
    chk(tag, rdata, exp);
    chk({tag, " model"}, rdata, exp_rd(a));
    req = 0;
  endtask

  task automatic msg(input logic [4:0] v);
    msg_valid = 1; msg_vec = v;
    @(negedge clk);
    msg_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle(3);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 msi lines", 32'(msi_irq), 0);
    chk("R1 legacy lines", 32'(leg_irq), 0);
    rd("R1 status g0", 12'h100, 0);
    rd("R1 enable g7", 12'h174, 0);

    // R4 enable set / read-back at both addresses
    wr(12'h104, 32'hF);
    rd("R4 enable via set addr", 12'h104, 32'hF);
    rd("R4 enable via clr addr", 12'h108, 32'hF);

    // R2 / R5 routing and output
    msg(5'd0);
    chk("R5 group0 asserted", 32'(msi_irq), 32'h01);
    rd("R2 vector 0 -> g0 b0", 12'h100, 32'h1);
    msg(5'd24);
    rd("R2 vector 24 -> g0 b3", 12'h100, 32'h9);
    msg(5'd13);
    rd("R2 vector 13 -> g5 b1", 12'h150, 32'h2);
    chk("R5 masked group5 quiet", 32'(msi_irq), 32'h01);

    // R3 write-one-to-clear
    wr(12'h100, 32'h1);
    rd("R3 w1c keeps zero bits", 12'h100, 32'h8);
    chk("R3 line still high", 32'(msi_irq), 32'h01);

    // R6 serve then quiet
    wr(12'h100, 32'h8);
    chk("R6 line drops", 32'(msi_irq), 32'h00);
    msg(5'd16);
    rd("R6 pending after service", 12'h100, 32'h4);
    idle(2);
    chk("R6 stays low until EOI", 32'(msi_irq), 32'h00);

    // R7 EOI
    wr(12'h040, 32'd5);
    chk("R7 wrong code no effect", 32'(msi_irq), 32'h00);
    wr(12'h040, 32'd4);
    chk("R7 eoi rearms group0", 32'(msi_irq), 32'h01);

    // R3 collision: set wins
    msg_valid = 1; msg_vec = 5'd16;
    wr(12'h100, 32'h4);
    msg_valid = 0;
    rd("R3 set wins collision", 12'h100, 32'h4);

    // R4 enable clear
    wr(12'h108, 32'hF);
    rd("R4 enable cleared", 12'h104, 32'h0);
    chk("R5 masked line low", 32'(msi_irq), 32'h00);

    // R8 legacy line 2
    wr(12'h1A4, 32'h1);
    legacy[2] = 1'b1;
    idle(2);
    chk("R8 sync latency", 32'(leg_irq), 32'h0);
    idle(1);
    chk("R8 legacy asserted", 32'(leg_irq), 32'h4);
    rd("R8 legacy status", 12'h1A0, 32'h1);
    legacy[2] = 1'b0;
    idle(3);
    chk("R8 status sticky", 32'(leg_irq), 32'h4);
    wr(12'h1A0, 32'h1);
    rd("R8 legacy status cleared", 12'h1A0, 32'h0);
    legacy[2] = 1'b1;
    idle(4);
    chk("R8 served legacy quiet", 32'(leg_irq), 32'h0);
    wr(12'h040, 32'd2);
    chk("R7 legacy eoi rearms", 32'(leg_irq), 32'h4);
    legacy[2] = 1'b0;

    // R9 unmapped
    rd("R9 unmapped 0x300", 12'h300, 0);
    rd("R9 unmapped 0x1C0", 12'h1C0, 0);
    rd("R9 eoi reads zero", 12'h040, 0);
    rd("R9 hole 0x10C", 12'h10C, 0);

    // Random phase against model (R2..R8)
    for (int it = 0; it < 4000; it++) begin
      int op;
      op = $urandom_range(0, 9);
      if ($urandom_range(0, 3) == 0) begin msg_valid = 1; msg_vec = 5'($urandom_range(0, 31)); end
      if ($urandom_range(0, 15) == 0) legacy = 4'($urandom);
      case (op)
        0, 1: begin req = 1; we = 1; addr = 12'('h100 + 16*$urandom_range(0, 7) + 4*$urandom_range(0, 2)); wdata = $urandom; end
        2:    begin req = 1; we = 1; addr = 12'('h180 + 16*$urandom_range(0, 3) + 4*$urandom_range(0, 2)); wdata = $urandom; end
        3, 4: begin req = 1; we = 1; addr = 12'h040; wdata = 32'($urandom_range(0, 13)); end
        5, 6: begin
          req = 1; we = 0;
          addr = ($urandom_range(0, 1) == 1) ? 12'('h100 + 16*$urandom_range(0, 11) + 4*$urandom_range(0, 3))
                                             : 12'($urandom);
          #0.5;
          chk("R9 random read model", rdata, exp_rd(addr));
        end
        default: ;
      endcase
      @(negedge clk);
      req = 0; we = 0; msg_valid = 0;
      chk_out("R5 R6 R7 R8 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule